// File: doc/BRIEF.md
# Powerdown and Self-Calibration Sequencer

This block converts one active-high control pin into the control signals of a clock-recovery loop. The same pin works as a level control and as an edge request. While it is high, the recovered data and recovered clock drivers are off and the loop logic is held in reset. When it falls after a long enough high interval, the loop is released from reset and runs a calibration phase of fixed length, followed by an acquisition phase. After that the block settles in a running state.

The pin is asynchronous, so it passes through a two-flop synchroniser and a glitch filter before any decision is made. Calibration runs only while a reference-activity flag is high. If the reference is missing, the sequence waits and restarts once the reference returns. If the high interval was too short to qualify, the block returns straight to running without calibrating and sets a sticky flag. The loss-of-lock alarm from the lock detector reaches the output only in the acquisition and running states. An unconnected pin reads low, so the reset state is normal running.

Top module: `pdcal_seq`

## Requirements
- R1: After reset with the control pin low, `drv_en`=1, `acq_en`=1, `loop_rst`=0, `cal_run`=0, `busy`=0, `cal_done`=0 and `short_pulse`=0.
- R2: While the filtered pin is high, `drv_en`=0, `acq_en`=0 and `loop_rst`=1. A pin high for at least 2 cycles reaches these outputs.
- R3: A pin pulse of a single clock cycle has no effect on any output.
- R4: A fall after at least `MIN_HIGH_CYC` high cycles, with the reference active, gives exactly `CAL_CYC` consecutive cycles of `cal_run`=1.
- R5: A qualified fall while `ref_active`=0 holds `busy`=1 and `cal_run`=0 until the reference returns. Calibration then runs for its full length.
- R6: If `ref_active` drops during calibration, calibration stops and later restarts from zero. The final uninterrupted run is exactly `CAL_CYC` cycles.
- R7: `cal_done` is a pulse of one cycle. It occurs once per completed calibration, in the cycle right after the last `cal_run` cycle.
- R8: After calibration, `busy` stays high for `ACQ_CYC` more cycles, with `acq_en`=1. A qualified sequence with the reference present keeps `busy` high for `CAL_CYC`+`ACQ_CYC` cycles in total.
- R9: A fall after fewer than `MIN_HIGH_CYC` (and at least 2) high cycles returns to running without calibration, with `busy` never high. It sets `short_pulse`, which stays set until reset.
- R10: `lol_out` equals `lol_in` AND `acq_en`, so the alarm is masked during powerdown, while waiting for the reference and during calibration.
- R11: Raising the pin during calibration aborts it at once and enters powerdown. The following qualified fall runs a complete new calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_cal_pin | input | 1 | Asynchronous powerdown / calibration request pin |
| ref_active | input | 1 | Reference clock activity flag |
| lol_in | input | 1 | Raw loss-of-lock alarm from the lock detector |
| drv_en | output | 1 | Enable for the recovered data and clock drivers |
| loop_rst | output | 1 | Reset for the loop logic |
| cal_run | output | 1 | Calibration phase active |
| acq_en | output | 1 | Loop acquisition / tracking enable |
| busy | output | 1 | Recovery sequence in progress (wait, calibrate, acquire) |
| cal_done | output | 1 | One-cycle pulse at calibration completion |
| short_pulse | output | 1 | Sticky flag: a high interval was too short to qualify |
| lol_out | output | 1 | Masked loss-of-lock alarm |

## Verification
The assertions check, on every cycle, several properties of the sequence. Each filtered edge is backed by two equal synchronised samples. A high filtered level forces powerdown. Calibration is entered only with the reference present and leaves only after its full count. `cal_done` is a single-cycle pulse at that exit. `short_pulse` never clears. The alarm stays masked while acquisition is disabled. Only the bench scenarios can show the behaviour that spans many cycles: the threshold between short and qualified pulses on both sides, the total busy duration, waiting and restart around a missing reference, and an abort by the pin during calibration.

// File: rtl/pdcal_pkg.sv
package pdcal_pkg;

    typedef enum logic [2:0] {
        ST_PDOWN   = 3'd0,
        ST_WAITREF = 3'd1,
        ST_CAL     = 3'd2,
        ST_ACQ     = 3'd3,
        ST_RUN     = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic drv_en;
        logic loop_rst;
        logic cal_run;
        logic acq_en;
        logic busy;
    } seq_ctl_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic seq_ctl_t decode_ctl(input seq_state_e s);
        seq_ctl_t c;
        c.drv_en   = (s != ST_PDOWN);
        c.loop_rst = (s == ST_PDOWN);
        c.cal_run  = (s == ST_CAL);
        c.acq_en   = (s == ST_ACQ) || (s == ST_RUN);
        c.busy     = (s == ST_WAITREF) || (s == ST_CAL) || (s == ST_ACQ);
        return c;
    endfunction

endpackage

// File: rtl/pdcal_input_cond.sv
module pdcal_input_cond (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic lvl
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= 1'b0;
            s2  <= 1'b0;
            s3  <= 1'b0;
            lvl <= 1'b0;
        end else begin
            s1 <= pin_async;
            s2 <= s1;
            s3 <= s2;
            if ((s2 == s3) && (s2 != lvl))
                lvl <= s2;
        end
    end

    // R3: the filtered level moves only after two equal synchronised samples
    assert_two_samples_R3: assert property (@(posedge clk) disable iff (rst)
        (lvl != $past(lvl)) |-> ($past(s2) == lvl) && ($past(s3) == lvl));

endmodule

// File: rtl/pdcal_high_timer.sv
module pdcal_high_timer #(
    parameter int unsigned MIN_HIGH_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic qualified
);
    localparam int unsigned HW = pdcal_pkg::cnt_width(MIN_HIGH_CYC);
    localparam logic [HW-1:0] LIMIT = HW'(MIN_HIGH_CYC);

    logic [HW-1:0] hcnt;

    always_ff @(posedge clk) begin
        if (rst)
            hcnt <= '0;
        else if (!lvl)
            hcnt <= '0;
        else if (hcnt != LIMIT)
            hcnt <= hcnt + 1'b1;
    end

    assign qualified = (hcnt == LIMIT);

    // R4: the high-interval count saturates at the threshold
    assert_high_sat_R4: assert property (@(posedge clk) disable iff (rst)
        hcnt <= LIMIT);

    // R9: the count restarts after every low level
    assert_high_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(lvl) |-> (hcnt == '0));

endmodule

// File: rtl/pdcal_phase_cnt.sv
module pdcal_phase_cnt #(
    parameter int unsigned PW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [PW-1:0] phase
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end
endmodule

// File: rtl/pdcal_fsm.sv
module pdcal_fsm
    import pdcal_pkg::*;
#(
    parameter int unsigned CAL_CYC = 64,
    parameter int unsigned ACQ_CYC = 32,
    parameter int unsigned PW      = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lvl,
    input  logic          qualified,
    input  logic          ref_active,
    input  logic [PW-1:0] phase,
    output logic          phase_clr,
    output seq_ctl_t      ctl,
    output logic          cal_done,
    output logic          short_pulse
);
    localparam logic [PW-1:0] CAL_LAST = PW'(CAL_CYC - 1);
    localparam logic [PW-1:0] ACQ_LAST = PW'(ACQ_CYC - 1);

    seq_state_e state, state_nxt;
    logic       short_set;

    always_comb begin
        state_nxt = state;
        short_set = 1'b0;
        if (lvl) begin
            state_nxt = ST_PDOWN;
        end else begin
            unique case (state)
                ST_PDOWN: begin
                    if (qualified)
                        state_nxt = ref_active ? ST_CAL : ST_WAITREF;
                    else begin
                        state_nxt = ST_RUN;
                        short_set = 1'b1;
                    end
                end
                ST_WAITREF: if (ref_active) state_nxt = ST_CAL;
                ST_CAL: begin
                    if (!ref_active)
                        state_nxt = ST_WAITREF;
                    else if (phase == CAL_LAST)
                        state_nxt = ST_ACQ;
                end
                ST_ACQ: if (phase == ACQ_LAST) state_nxt = ST_RUN;
                default: state_nxt = ST_RUN;
            endcase
        end
    end

    assign phase_clr = (state_nxt != state);
    assign ctl       = decode_ctl(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_RUN;
            cal_done    <= 1'b0;
            short_pulse <= 1'b0;
        end else begin
            state       <= state_nxt;
            cal_done    <= (state == ST_CAL) && (state_nxt == ST_ACQ);
            if (short_set)
                short_pulse <= 1'b1;
        end
    end

    // R2: a high filtered level always lands in powerdown
    assert_pd_level_R2: assert property (@(posedge clk) disable iff (rst)
        $past(lvl) |-> (state == ST_PDOWN));

    // R5: calibration is entered only with the reference present
    assert_cal_entry_ref_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAL && $past(state) != ST_CAL) |-> $past(ref_active));

    // R4: calibration hands over to acquisition only after its full count
    assert_cal_len_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACQ && $past(state) == ST_CAL) |-> ($past(phase) == CAL_LAST));

    // R7: done is a single-cycle pulse at the exit from calibration
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> !cal_done);
    assert_done_exit_R7: assert property (@(posedge clk) disable iff (rst)
        cal_done |-> ($past(state) == ST_CAL) && (state == ST_ACQ));

    // R9: the short-interval flag never clears without reset
    assert_short_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        $past(short_pulse) |-> short_pulse);

endmodule

// File: rtl/pdcal_seq.sv
module pdcal_seq
    import pdcal_pkg::*;
#(
    parameter int unsigned MIN_HIGH_CYC = 50,
    parameter int unsigned CAL_CYC      = 64,
    parameter int unsigned ACQ_CYC      = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_cal_pin,
    input  logic ref_active,
    input  logic lol_in,
    output logic drv_en,
    output logic loop_rst,
    output logic cal_run,
    output logic acq_en,
    output logic busy,
    output logic cal_done,
    output logic short_pulse,
    output logic lol_out
);
    localparam int unsigned PH_MAX = (CAL_CYC > ACQ_CYC) ? CAL_CYC : ACQ_CYC;
    localparam int unsigned PW     = cnt_width(PH_MAX);

    logic          lvl;
    logic          qualified;
    logic          phase_clr;
    logic [PW-1:0] phase;
    seq_ctl_t      ctl;

    pdcal_input_cond u_cond (
        .clk       (clk),
        .rst       (rst),
        .pin_async (pd_cal_pin),
        .lvl       (lvl)
    );

    pdcal_high_timer #(.MIN_HIGH_CYC(MIN_HIGH_CYC)) u_htimer (
        .clk       (clk),
        .rst       (rst),
        .lvl       (lvl),
        .qualified (qualified)
    );

    pdcal_phase_cnt #(.PW(PW)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .clr   (phase_clr),
        .phase (phase)
    );

    pdcal_fsm #(.CAL_CYC(CAL_CYC), .ACQ_CYC(ACQ_CYC), .PW(PW)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .lvl         (lvl),
        .qualified   (qualified),
        .ref_active  (ref_active),
        .phase       (phase),
        .phase_clr   (phase_clr),
        .ctl         (ctl),
        .cal_done    (cal_done),
        .short_pulse (short_pulse)
    );

    assign drv_en   = ctl.drv_en;
    assign loop_rst = ctl.loop_rst;
    assign cal_run  = ctl.cal_run;
    assign acq_en   = ctl.acq_en;
    assign busy     = ctl.busy;
    assign lol_out  = lol_in & ctl.acq_en;

    // R10: the alarm is silent whenever acquisition is not enabled
    assert_lol_mask_R10: assert property (@(posedge clk) disable iff (rst)
        !acq_en |-> !lol_out);

    // R2: drivers never run while the loop is held in reset
    assert_drv_off_R2: assert property (@(posedge clk) disable iff (rst)
        loop_rst |-> !drv_en);

endmodule

// File: tb/pdcal_seq_bench.sv
module pdcal_seq_bench;
    localparam int MINH = 50;
    localparam int CALC = 64;
    localparam int ACQC = 32;
    localparam int NV   = 6;

    localparam int VEC_LEN   [NV] = '{1, 2, MINH-1, MINH, MINH+1, 200};
    localparam int VEC_PD    [NV] = '{0, 1, 1, 1, 1, 1};
    localparam int VEC_CAL   [NV] = '{0, 0, 0, CALC, CALC, CALC};
    localparam int VEC_BUSY  [NV] = '{0, 0, 0, CALC+ACQC, CALC+ACQC, CALC+ACQC};
    localparam int VEC_SHORT [NV] = '{0, 1, 1, 1, 1, 1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd_cal_pin = 1'b0;
    logic ref_active = 1'b1;
    logic lol_in = 1'b1;
    logic drv_en, loop_rst, cal_run, acq_en, busy, cal_done, short_pulse, lol_out;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    int pd_seen, cal_tot, run_len, longest, busy_tot, done_cnt, done_bad, lol_bad;
    logic prev_cal;

    always #10 clk = ~clk;

    pdcal_seq #(.MIN_HIGH_CYC(MINH), .CAL_CYC(CALC), .ACQ_CYC(ACQC)) u_pdcal_seq (
        .clk(clk), .rst(rst), .pd_cal_pin(pd_cal_pin), .ref_active(ref_active),
        .lol_in(lol_in), .drv_en(drv_en), .loop_rst(loop_rst), .cal_run(cal_run),
        .acq_en(acq_en), .busy(busy), .cal_done(cal_done),
        .short_pulse(short_pulse), .lol_out(lol_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic mon_clear();
        pd_seen = 0; cal_tot = 0; run_len = 0; longest = 0;
        busy_tot = 0; done_cnt = 0; done_bad = 0; lol_bad = 0; prev_cal = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
        if (!drv_en) pd_seen = 1;
        if (cal_run) begin
            cal_tot++; run_len++;
            if (run_len > longest) longest = run_len;
        end else run_len = 0;
        if (busy) busy_tot++;
        if (cal_done) begin
            done_cnt++;
            if (!(prev_cal && !cal_run)) done_bad++;
        end
        if (lol_out !== (lol_in & acq_en)) lol_bad++;
        prev_cal = cal_run;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pulse(input int len);
        pd_cal_pin = 1'b1;
        steps(len);
        pd_cal_pin = 1'b0;
    endtask

    task automatic wait_cal();
        for (int i = 0; i < 500 && !cal_run; i++) step();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        mon_clear();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        steps(6);
        // R1 reset state
        chk("R1 drv_en",      drv_en,      1);
        chk("R1 acq_en",      acq_en,      1);
        chk("R1 loop_rst",    loop_rst,    0);
        chk("R1 cal_run",     cal_run,     0);
        chk("R1 busy",        busy,        0);
        chk("R1 cal_done",    cal_done,    0);
        chk("R1 short_pulse", short_pulse, 0);
        chk("R10 lol pass",   lol_out,     1);

        // table walk: R3 glitch, R9 short, R4/R7/R8 qualified
        for (int v = 0; v < NV; v++) begin
            mon_clear();
            pulse(VEC_LEN[v]);
            steps(CALC + ACQC + 20);
            chk($sformatf("R2/R3 powerdown seen v%0d", v), pd_seen, VEC_PD[v]);
            chk($sformatf("R4 cal cycles v%0d", v), cal_tot, VEC_CAL[v]);
            chk($sformatf("R8 busy cycles v%0d", v), busy_tot, VEC_BUSY[v]);
            chk($sformatf("R7 done pulses v%0d", v), done_cnt, (VEC_CAL[v] != 0) ? 1 : 0);
            chk($sformatf("R7 done timing v%0d", v), done_bad, 0);
            chk($sformatf("R9 short flag v%0d", v), short_pulse, VEC_SHORT[v]);
            chk($sformatf("R10 lol masking v%0d", v), lol_bad, 0);
            chk($sformatf("R8 running v%0d", v), acq_en & drv_en & !busy, 1);
        end

        // R2: level held high keeps drivers off
        mon_clear();
        pd_cal_pin = 1'b1;
        steps(10);
        chk("R2 drv_en off",   drv_en,   0);
        chk("R2 loop_rst on",  loop_rst, 1);
        chk("R2 acq_en off",   acq_en,   0);
        chk("R10 lol masked pd", lol_out, 0);
        steps(MINH);
        ref_active = 1'b0;
        pd_cal_pin = 1'b0;

        // R5: waiting for reference
        steps(100);
        chk("R5 busy waiting",    busy,    1);
        chk("R5 no cal w/o ref",  cal_run, 0);
        chk("R5 acq_en off",      acq_en,  0);
        chk("R10 lol masked wait", lol_out, 0);
        chk("R2 drivers back",    drv_en,  1);
        mon_clear();
        ref_active = 1'b1;
        steps(CALC + ACQC + 20);
        chk("R5 cal after ref",  longest,  CALC);
        chk("R7 done after ref", done_cnt, 1);

        // R6: reference lost mid-calibration
        mon_clear();
        pulse(MINH + 10);
        wait_cal();
        steps(10);
        ref_active = 1'b0;
        steps(5);
        ref_active = 1'b1;
        steps(CALC + ACQC + 20);
        chk("R6 restart full run", longest, CALC);
        chk("R6 total exceeds", (cal_tot > CALC) ? 1 : 0, 1);
        chk("R6 single done", done_cnt, 1);
        chk("R10 lol masking R6", lol_bad, 0);

        // R11: pin raised during calibration aborts it
        mon_clear();
        pulse(MINH + 10);
        wait_cal();
        steps(5);
        pd_cal_pin = 1'b1;
        steps(5);
        chk("R11 cal aborted", cal_run,  0);
        chk("R11 loop reset",  loop_rst, 1);
        chk("R11 drivers off", drv_en,   0);
        chk("R11 no done", done_cnt, 0);
        steps(MINH);
        pd_cal_pin = 1'b0;
        mon_clear();
        steps(CALC + ACQC + 20);
        chk("R11 new full cal", longest,  CALC);
        chk("R11 done once",    done_cnt, 1);
        chk("R11 running",      acq_en & !busy, 1);

        // R9: flag stays set until reset, then clears
        chk("R9 sticky", short_pulse, 1);
        rst = 1'b1;
        steps(2);
        rst = 1'b0;
        steps(4);
        chk("R1 short cleared by reset", short_pulse, 0);

        done_flag = 1'b1;
        summary();
        $finish;
    end
endmodule